// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block follows a linked-in-memory list of fixed 8-byte descriptors on behalf of one transfer channel. Software places the descriptors back to back in memory and pulses a start strobe with the address of the first one. The walker reads each descriptor as two 32-bit words, decodes it, and hands a buffer address and byte count to a downstream data mover. It waits for the mover to report that the transfer is done before it fetches the next descriptor.

When the descriptor that carries the end-of-list flag has been handled, the walker emits a one-cycle completion pulse and returns to idle. A malformed descriptor stops the walk with an error flag instead. A stop strobe abandons the walk at any point. The block only sequences commands and never touches payload data.

Descriptor layout, little-endian. The low word is at the descriptor address and holds these fields:
- bits 7:0 are the flag byte;
- bits 15:8 are reserved;
- bits 31:16 are the length.

The high word is at address + 4 and holds the buffer address.

Top module: `sgw_walker`

## Requirements
- R1: After reset, mem_req, cmd_valid, walk_done and walk_err are all low, and they stay low until a start is accepted.
- R2: An accepted start reads the descriptor at start_addr, and the descriptor at list position n sits at start_addr + 8n. Each descriptor is read as two single-word reads: first the low word at its base, then the high word at base + 4. At most one read is outstanding at any time.
- R3: Decoding works on the low word. Bit 0 is "valid", bit 1 is "end of list", bit 5 is "transfer", and bits 31:16 are the byte length. The high word is the buffer address. Bits 15:8 and the other flag bits have no effect.
- R4: A well-formed descriptor with the transfer bit set produces exactly one command carrying its address and length. cmd_valid stays high, with cmd_addr and cmd_len unchanged, until cmd_ready is sampled high.
- R5: After a command is accepted, no memory read is issued until cmd_done has been sampled high.
- R6: A well-formed descriptor with the transfer bit clear issues no command. The walk goes straight on to the next descriptor, or ends if that descriptor is marked last.
- R7: Once the last descriptor has been handled (its command done, or skipped per R6), walk_done is high for exactly one cycle and the walker returns to idle.
- R8: A descriptor is malformed if its valid bit is clear, its length is zero, or its length is not a multiple of 4. A malformed descriptor issues no command, stops the walk without walk_done, and sets walk_err. walk_err stays high until the next accepted start or a stop.
- R9: A stop strobe, in any state, returns the walker to idle on the next edge. After that edge cmd_valid, mem_req, walk_done and walk_err are low, and no further reads or completion pulse follow.
- R10: A start strobe while a walk is in progress is ignored, and the running walk finishes with its own list.
- R11: The largest legal length, 65532, is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk at start_addr (only taken when idle) |
| start_addr | input | LIST_AW | Address of the first descriptor, 8-byte aligned |
| stop | input | 1 | Abort the current walk |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | LIST_AW | Word address of the read |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Transfer command offered to the mover |
| cmd_ready | input | 1 | Mover accepts the command |
| cmd_addr | output | 32 | Buffer address of the command |
| cmd_len | output | 16 | Byte length of the command |
| cmd_done | input | 1 | Mover reports the accepted command finished |
| walk_done | output | 1 | One-cycle pulse: list completed |
| walk_err | output | 1 | Walk stopped on a malformed descriptor |

## Verification
The bench uses the default 32-bit list address width and a 64-word memory model. It sweeps every combination of three things:
- chain lengths of one to four descriptors;
- read latencies of one to three cycles;
- six descriptor patterns, each applied to the middle descriptor: plain, transfer bit clear, valid bit clear, length off by two, length zero, and the maximum length.

Because the mover's ready gap and done delay are tied to the sweep indices, every state of the walker meets back-pressure of differing lengths. Separate runs cover a stop during a fetch, a stop while a command is offered, a stop while a done is awaited, and a start while busy. The expected command list and outcome come from scanning the memory image in the bench.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LEN_W      = 16;
  localparam int unsigned BUF_AW     = 32;

  // flag bit positions inside the low word
  localparam int unsigned FLG_VALID = 0;
  localparam int unsigned FLG_LAST  = 1;
  localparam int unsigned FLG_XFER  = 5;

  typedef struct packed {
    logic              valid;
    logic              last;
    logic              xfer;
    logic [LEN_W-1:0]  len;
    logic [BUF_AW-1:0] addr;
  } sgw_desc_t;

  typedef enum logic [1:0] {
    W_IDLE,
    W_FETCH,
    W_ISSUE,
    W_WAIT
  } sgw_state_t;

  function automatic sgw_desc_t sgw_unpack(input logic [WORD_W-1:0] lo,
                                           input logic [WORD_W-1:0] hi);
    sgw_desc_t d;
    d.valid = lo[FLG_VALID];
    d.last  = lo[FLG_LAST];
    d.xfer  = lo[FLG_XFER];
    d.len   = lo[WORD_W-1 -: LEN_W];
    d.addr  = hi[BUF_AW-1:0];
    return d;
  endfunction

  function automatic logic sgw_len_legal(input logic [LEN_W-1:0] len);
    return (len != '0) && (len[1:0] == 2'b00);
  endfunction

endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch #(
  parameter int unsigned LIST_AW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       abort,
  input  logic                       go,
  input  logic [LIST_AW-1:0]         base,
  output logic                       mem_req,
  output logic [LIST_AW-1:0]         mem_addr,
  input  logic                       mem_rvalid,
  input  logic [sgw_pkg::WORD_W-1:0] mem_rdata,
  output logic [sgw_pkg::WORD_W-1:0] word_lo,
  output logic [sgw_pkg::WORD_W-1:0] word_hi,
  output logic                       fetched
);
  localparam int unsigned WORD_BYTES = sgw_pkg::WORD_W / 8;

  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fphase_t;
  fphase_t phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= F_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      word_lo  <= '0;
      word_hi  <= '0;
      fetched  <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      fetched <= 1'b0;
      if (abort) begin
        phase <= F_IDLE;
      end else begin
        unique case (phase)
          F_IDLE: if (go) begin
            mem_req  <= 1'b1;
            mem_addr <= base;
            phase    <= F_LO;
          end
          F_LO: if (mem_rvalid) begin
            word_lo  <= mem_rdata;
            mem_req  <= 1'b1;
            mem_addr <= mem_addr + LIST_AW'(WORD_BYTES);
            phase    <= F_HI;
          end
          F_HI: if (mem_rvalid) begin
            word_hi <= mem_rdata;
            fetched <= 1'b1;
            phase   <= F_IDLE;
          end
          default: phase <= F_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sgw_decode.sv
module sgw_decode (
  input  logic [sgw_pkg::WORD_W-1:0] word_lo,
  input  logic [sgw_pkg::WORD_W-1:0] word_hi,
  output sgw_pkg::sgw_desc_t         desc,
  output logic                       desc_ok
);
  import sgw_pkg::*;

  // reserved byte and spare flag bits take no part in decoding
  logic unused_fields;
  assign unused_fields = ^{word_lo[15:8], word_lo[7:6], word_lo[4:2]};

  always_comb begin
    desc    = sgw_unpack(word_lo, word_hi);
    desc_ok = desc.valid && sgw_len_legal(desc.len);
  end
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker #(
  parameter int unsigned LIST_AW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [LIST_AW-1:0]         start_addr,
  input  logic                       stop,
  output logic                       mem_req,
  output logic [LIST_AW-1:0]         mem_addr,
  input  logic                       mem_rvalid,
  input  logic [sgw_pkg::WORD_W-1:0] mem_rdata,
  output logic                       cmd_valid,
  input  logic                       cmd_ready,
  output logic [sgw_pkg::BUF_AW-1:0] cmd_addr,
  output logic [sgw_pkg::LEN_W-1:0]  cmd_len,
  input  logic                       cmd_done,
  output logic                       walk_done,
  output logic                       walk_err
);
  import sgw_pkg::*;

  sgw_state_t           state;
  logic [LIST_AW-1:0]   ptr;
  logic                 last_q;

  logic [WORD_W-1:0]    word_lo, word_hi;
  logic                 fetched;
  sgw_desc_t            desc;
  logic                 desc_ok;

  // named events
  logic                 start_take;
  logic                 bad_ev;
  logic                 skip_ev;
  logic                 issue_ev;
  logic                 accept_ev;
  logic                 finish_ev;
  logic                 adv_go;
  logic                 fetch_go;
  logic [LIST_AW-1:0]   fetch_base;

  always_comb begin
    start_take = start && !stop && (state == W_IDLE);
    bad_ev     = (state == W_FETCH) && fetched && !desc_ok;
    skip_ev    = (state == W_FETCH) && fetched && desc_ok && !desc.xfer;
    issue_ev   = (state == W_FETCH) && fetched && desc_ok && desc.xfer;
    accept_ev  = (state == W_ISSUE) && cmd_ready;
    finish_ev  = (state == W_WAIT) && cmd_done;
    adv_go     = !stop && ((skip_ev && !desc.last) || (finish_ev && !last_q));
    fetch_go   = start_take || adv_go;
    fetch_base = start_take ? start_addr : ptr + LIST_AW'(DESC_BYTES);
  end

  sgw_fetch #(.LIST_AW(LIST_AW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (stop),
    .go         (fetch_go),
    .base       (fetch_base),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .word_lo    (word_lo),
    .word_hi    (word_hi),
    .fetched    (fetched)
  );

  sgw_decode u_decode (
    .word_lo (word_lo),
    .word_hi (word_hi),
    .desc    (desc),
    .desc_ok (desc_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= W_IDLE;
      ptr       <= '0;
      last_q    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_len   <= '0;
      walk_done <= 1'b0;
      walk_err  <= 1'b0;
    end else begin
      walk_done <= 1'b0;
      if (fetch_go) ptr <= fetch_base;
      if (stop) begin
        state     <= W_IDLE;
        cmd_valid <= 1'b0;
        walk_err  <= 1'b0;
      end else begin
        unique case (state)
          W_IDLE: if (start_take) begin
            walk_err <= 1'b0;
            state    <= W_FETCH;
          end
          W_FETCH: begin
            if (bad_ev) begin
              walk_err <= 1'b1;
              state    <= W_IDLE;
            end else if (issue_ev) begin
              cmd_valid <= 1'b1;
              cmd_addr  <= desc.addr;
              cmd_len   <= desc.len;
              last_q    <= desc.last;
              state     <= W_ISSUE;
            end else if (skip_ev && desc.last) begin
              walk_done <= 1'b1;
              state     <= W_IDLE;
            end
          end
          W_ISSUE: if (accept_ev) begin
            cmd_valid <= 1'b0;
            state     <= W_WAIT;
          end
          W_WAIT: if (finish_ev) begin
            if (last_q) begin
              walk_done <= 1'b1;
              state     <= W_IDLE;
            end else begin
              state <= W_FETCH;
            end
          end
          default: state <= W_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sgw_walker_chk.sv
module sgw_walker_chk #(
  parameter int unsigned LIST_AW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stop,
  input logic               mem_req,
  input logic               mem_rvalid,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [31:0]        cmd_addr,
  input logic [15:0]        cmd_len,
  input logic               cmd_done,
  input logic               walk_done,
  input logic               walk_err
);
  logic req_open;
  logic cmd_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_open <= 1'b0;
      cmd_open <= 1'b0;
    end else begin
      if (stop || mem_rvalid) req_open <= 1'b0;
      else if (mem_req)       req_open <= 1'b1;
      if (stop || cmd_done)                  cmd_open <= 1'b0;
      else if (cmd_valid && cmd_ready)       cmd_open <= 1'b1;
    end
  end

  p_one_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_open);

  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !stop) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)));

  p_no_fetch_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cmd_open);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);

  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_done && walk_err));

  p_len_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len != 16'd0 && cmd_len[1:0] == 2'b00));

  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!cmd_valid && !mem_req && !walk_done && !walk_err));
endmodule

bind sgw_walker sgw_walker_chk #(.LIST_AW(LIST_AW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop       (stop),
  .mem_req    (mem_req),
  .mem_rvalid (mem_rvalid),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_addr   (cmd_addr),
  .cmd_len    (cmd_len),
  .cmd_done   (cmd_done),
  .walk_done  (walk_done),
  .walk_err   (walk_err)
);

// File: tb/test_sgw_walker.sv
module test_sgw_walker;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        stop = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [31:0] cmd_addr;
  logic [15:0] cmd_len;
  logic        cmd_done;
  logic        walk_done;
  logic        walk_err;

  sgw_walker i_sgw_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .stop(stop),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_done(cmd_done), .walk_done(walk_done), .walk_err(walk_err)
  );

  int checks = 0;
  int errors = 0;

  // memory model with selectable latency
  logic [31:0] mem [64];
  int          lat = 1;
  logic [1:0]  lsel;
  logic [3:0]  pv;
  logic [31:0] pd [4];
  assign lsel       = 2'(lat - 1);
  assign mem_rvalid = pv[lsel];
  assign mem_rdata  = pd[lsel];

  // mover model and counters
  int          rdy_gap = 0;
  int          done_dly = 0;
  int          rdy_ctr;
  int          dcnt;
  logic        pend;
  logic        clr = 1'b0;
  logic [31:0] log_a [16];
  logic [15:0] log_l [16];
  int          log_n, done_n, req_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0; cmd_ready <= 1'b0; cmd_done <= 1'b0; rdy_ctr <= 0; pend <= 1'b0; dcnt <= 0;
      log_n <= 0; done_n <= 0; req_n <= 0;
    end else begin
      pv    <= {pv[2:0], mem_req};
      pd[0] <= mem[mem_addr[7:2]];
      pd[1] <= pd[0]; pd[2] <= pd[1]; pd[3] <= pd[2];
      cmd_ready <= (rdy_ctr == 0);
      rdy_ctr   <= (rdy_ctr >= rdy_gap) ? 0 : rdy_ctr + 1;
      cmd_done  <= 1'b0;
      if (cmd_valid && cmd_ready) begin
        log_a[log_n[3:0]] <= cmd_addr;
        log_l[log_n[3:0]] <= cmd_len;
        log_n <= log_n + 1;
        pend  <= 1'b1;
        dcnt  <= done_dly;
      end else if (pend) begin
        if (dcnt == 0) begin cmd_done <= 1'b1; pend <= 1'b0; end
        else dcnt <= dcnt - 1;
      end
      if (walk_done) done_n <= done_n + 1;
      if (mem_req)   req_n  <= req_n + 1;
      if (clr) begin log_n <= 0; done_n <= 0; req_n <= 0; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // expected result from scanning the image (R3, R6, R7, R8 rules)
  int          exp_n;
  bit          exp_done, exp_err;
  logic [31:0] exp_a [8];
  logic [15:0] exp_l [8];

  task automatic predict(input int idx);
    exp_n = 0; exp_done = 0; exp_err = 0;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] lo = mem[idx + 2*i];
      logic [31:0] hi = mem[idx + 2*i + 1];
      int ln = int'(lo[31:16]);
      if (lo[0] == 1'b0 || ln == 0 || (ln % 4) != 0) begin exp_err = 1; break; end
      if (lo[5]) begin exp_a[exp_n] = hi; exp_l[exp_n] = lo[31:16]; exp_n++; end
      if (lo[1]) begin exp_done = 1; break; end
    end
  endtask

  task automatic build(input int idx, input int k, input int v, input int off);
    int j = k / 2;
    for (int i = 0; i < k; i++) begin
      logic [7:0]  fl = 8'h21 | ((i == k-1) ? 8'h02 : 8'h00);
      logic [15:0] ln = 16'(4*(i+1) + 4*v);
      logic [31:0] a  = 32'h4000_0000 + 32'(off) + 32'(i*256) + 32'(v*16);
      if (i == j) begin
        case (v)
          1: fl = fl & ~8'h20;
          2: fl = fl & ~8'h01;
          3: ln = ln + 16'd2;
          4: ln = 16'd0;
          5: ln = 16'hFFFC;
          default: ;
        endcase
      end
      mem[idx + 2*i]     = {ln, 8'hA5 ^ 8'(i), fl};
      mem[idx + 2*i + 1] = a;
    end
  endtask

  task automatic wait_end(input string req);
    int t = 0;
    while (!(walk_err || done_n > 0) && t < 3000) begin @(negedge clk); t++; end
    chk(t < 3000, req, "walk ended", t, 0);
    repeat (5) @(negedge clk);
  endtask

  task automatic compare(input int idx, input string tag);
    predict(idx);
    chk(walk_err == exp_err, "R8", {tag, " err"}, walk_err, exp_err);
    chk(done_n == int'(exp_done), "R7", {tag, " done pulses"}, done_n, exp_done);
    chk(log_n == exp_n, "R4", {tag, " cmd count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_a[i] == exp_a[i], "R2", {tag, " cmd addr"}, log_a[i], exp_a[i]);
      chk(log_l[i] == exp_l[i], "R3", {tag, " cmd len"}, log_l[i], exp_l[i]);
    end
  endtask

  task automatic kick(input int idx);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    start = 1'b1; start_addr = 32'(idx*4); @(negedge clk); start = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: idle after reset
    chk(!mem_req && !cmd_valid && !walk_done && !walk_err, "R1", "reset outputs",
        {mem_req, cmd_valid, walk_done, walk_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req && !cmd_valid && !walk_done && !walk_err, "R1", "idle outputs",
        {mem_req, cmd_valid, walk_done, walk_err}, 0);

    // sweep: variants 1 = R6 skip, 2..4 = R8 malformed, 5 = R11 max length
    for (int k = 1; k <= 4; k++)
      for (int l = 1; l <= 3; l++)
        for (int v = 0; v <= 5; v++) begin
          lat = l; rdy_gap = (k + v) % 3; done_dly = v;
          for (int i = 0; i < 16; i++) mem[i] = '0;
          build(0, k, v, k * 4096);
          kick(0);
          wait_end("R7");
          compare(0, $sformatf("k%0d lat%0d v%0d", k, l, v));
          if (v == 5) begin
            predict(0);
            if (exp_n > k/2) chk(log_l[k/2] == 16'hFFFC, "R11", "max length",
                                 log_l[k/2], 16'hFFFC);
          end
        end

    // R8: error held while idle, cleared by stop
    lat = 1; rdy_gap = 0; done_dly = 0;
    build(0, 2, 4, 0);
    kick(0); wait_end("R8");
    repeat (10) @(negedge clk);
    chk(walk_err == 1'b1, "R8", "err held", walk_err, 1);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    chk(walk_err == 1'b0, "R8", "err cleared by stop", walk_err, 0);

    // R9: stop while waiting for done
    build(0, 4, 0, 0); done_dly = 20;
    kick(0);
    for (int t = 0; t < 200 && log_n < 1; t++) @(negedge clk);
    stop = 1'b1; clr = 1'b1; @(negedge clk); stop = 1'b0; clr = 1'b0;
    chk(!cmd_valid && !mem_req, "R9", "quiet after stop (wait)", {cmd_valid, mem_req}, 0);
    repeat (40) @(negedge clk);
    chk(done_n == 0 && req_n == 0 && !walk_err, "R9", "no activity after stop",
        done_n + req_n, 0);

    // R9: stop while command offered
    done_dly = 0; rdy_gap = 30;
    kick(0);
    for (int t = 0; t < 200 && !cmd_valid; t++) @(negedge clk);
    chk(cmd_valid == 1'b1, "R4", "command offered", cmd_valid, 1);
    stop = 1'b1; clr = 1'b1; @(negedge clk); stop = 1'b0; clr = 1'b0;
    chk(!cmd_valid, "R9", "cmd_valid drops on stop", cmd_valid, 0);
    repeat (60) @(negedge clk);
    chk(log_n == 0 && done_n == 0 && req_n == 0, "R9", "nothing after stop (issue)",
        log_n + done_n + req_n, 0);

    // R9: stop during a fetch
    rdy_gap = 0; lat = 3;
    kick(0);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    repeat (30) @(negedge clk);
    chk(log_n == 0 && done_n == 0, "R9", "stop in fetch", log_n + done_n, 0);

    // walker recovers after aborts
    lat = 2;
    kick(0); wait_end("R9"); compare(0, "after stops");

    // R10: start while busy ignored
    build(0, 3, 0, 0);
    build(32, 2, 0, 32'h8000);
    done_dly = 2; lat = 1;
    kick(0);
    repeat (3) @(negedge clk);
    start = 1'b1; start_addr = 32'h80; @(negedge clk); start = 1'b0;
    wait_end("R10");
    compare(0, "R10 busy start");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule